// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block provides three independent 16-bit down counters behind a small byte-wide host bus. Each channel counts on the cycles where its count-enable input is high. It counts only while its gate input is high, and it drives one output whose waveform depends on the programmed mode. Three modes are supported: a single terminal-count event, a periodic one-tick low pulse (rate generator) and a square wave. Each channel counts in either plain binary or four-digit BCD.

The host uses a 2-bit address. Ports 0 to 2 carry count bytes for channels 0 to 2, and port 3 takes a control byte. A control byte either reprograms a channel or takes a snapshot of its running count. Count values move over the 8-bit bus one byte at a time, in the order that the control byte chose. A snapshot stays frozen while the counter keeps running, so software can read a consistent 16-bit value without stopping the count. A typical use derives a periodic interrupt: the reload value is the count-clock rate divided by the wanted frequency, rounded to the nearest integer.

Top module: `pit_timer`

## Requirements
- R1: After reset every output is high, no channel counts, and every channel is set to mode 0, binary, low-then-high byte order, with a count of 0 and both byte pointers on the low byte.
- R2: A write to port 3 is decoded as follows. Bits 7:6 pick the channel (3 selects none and the byte is ignored). Bits 5:4 pick the access (0 snapshot, 1 low byte only, 2 high byte only, 3 low then high). Bits 3:1 pick the mode (0 terminal count, 2 or 6 rate generator, 3 or 7 square wave). Bit 0 set selects BCD. A byte naming mode 1, 4 or 5 changes nothing.
- R3: In low-then-high access, port writes alternate between the low and high byte, and the count is complete on the high byte. A low-only or high-only write sets the other byte to zero. A programming byte returns both the write and the read pointer to the low byte.
- R4: A completed count write is taken into the counter on the next count-enable cycle, whatever the gate level. That cycle does not decrement.
- R5: In mode 0 the output goes low on the programming byte and on a completed count write. It goes high on the enabled cycle that takes the count from 1 to 0, and stays high while the counter wraps and keeps counting.
- R6: In mode 2 with reload N ≥ 2, the output is low for exactly the one enabled cycle in which the count is 1. The next enabled cycle reloads N and raises the output, giving a period of N.
- R7: In mode 3 with reload N ≥ 2, the output is high for ceil(N/2) enabled cycles and low for floor(N/2), repeating.
- R8: With BCD selected, the count steps down through decimal digits (0x0100 is followed by 0x0099). A reload is then taken as a decimal value.
- R9: A reload of 0 behaves as 65536 in binary (the first decrement gives 0xFFFF) and as 10000 in BCD (the first decrement gives 0x9999).
- R10: While a channel's gate is low, enabled cycles leave its count and output unchanged.
- R11: A snapshot command copies the running count into a hold register, and port reads then return that value while counting goes on. The hold is released after the high byte is read (low-then-high access) or after one read (single-byte access). Further snapshot commands are ignored while a hold is active.
- R12: Without a hold, a port read returns the live count byte chosen by the access setting and the read pointer. A read of port 3 returns 0.
- R13: Count enables, gates, and writes for one channel leave the other channels' counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Port select: 0-2 channel data, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; advances the read pointer |
| bus_rdata | output | 8 | Read data for the addressed port |
| tick_en | input | 3 | Per-channel count enable |
| gate | input | 3 | Per-channel gate; low suspends counting |
| tmr_out | output | 3 | Per-channel timer output |

## Verification
The bench sweeps the reload value over a range in each mode. In mode 0 this checks the exact cycle of the terminal-count edge. In modes 2 and 3 it compares every output sample of two full periods, so the pulse position and the odd-reload uneven split of the square wave are told apart. Separate patterns load BCD values whose decrement crosses a digit boundary, and zero reloads in both number systems to separate the wrap behaviour. Snapshot sequences interleave counting between the snapshot and the reads, so a hold that tracked the live count would show. Single-byte accesses, pointer resets, reserved modes, low gates, and enables for other channels are each checked against the live count read over the bus.

// File: rtl/pit_pkg.sv
// Shared types for the interval timer: access kinds, counting modes and
// the mapping from the raw 3-bit mode field to a supported mode.
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        MODE_TC     = 2'd0,
        MODE_RATE   = 2'd1,
        MODE_SQUARE = 2'd2
    } mode_e;

    typedef struct packed {
        logic  ok;
        mode_e mode;
    } mode_sel_t;

    // Map the raw mode field; unsupported encodings return ok = 0.
    function automatic mode_sel_t map_mode(input logic [2:0] raw);
        mode_sel_t r;
        r.ok   = 1'b1;
        r.mode = MODE_TC;
        case (raw)
            3'd0:         r.mode = MODE_TC;
            3'd2, 3'd6:   r.mode = MODE_RATE;
            3'd3, 3'd7:   r.mode = MODE_SQUARE;
            default:      r.ok   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pit_decrement.sv
// Combinational count step for one channel. Subtracts 1 or 2 from the
// current count, either as a plain binary number or digit by digit in BCD.
// Assumes CNT_W is a multiple of 4; BCD results are only meaningful when
// the input holds valid decimal digits.
module pit_decrement #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             bcd,
    input  logic             by_two,
    output logic [CNT_W-1:0] nxt
);
    localparam int DIGITS = CNT_W / 4;

    logic [CNT_W-1:0] bin_next;
    logic [CNT_W-1:0] bcd_next;

    // True when every nibble of v is a decimal digit.
    function automatic logic digits_ok(input logic [CNT_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (v[4*d +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    // Binary step: plain subtraction with natural wrap.
    always_comb begin : bin_step
        bin_next = cur - (by_two ? CNT_W'(2) : CNT_W'(1));
    end

    // Decimal step: ripple a borrow through the digits.
    always_comb begin : bcd_step
        logic [4:0] borrow;
        logic [4:0] dig;
        logic [4:0] res;
        borrow   = by_two ? 5'd2 : 5'd1;
        bcd_next = '0;
        for (int d = 0; d < DIGITS; d++) begin
            dig = {1'b0, cur[4*d +: 4]};
            if (dig >= borrow) begin
                res    = dig - borrow;
                borrow = 5'd0;
            end else begin
                res    = dig + 5'd10 - borrow;
                borrow = 5'd1;
            end
            bcd_next[4*d +: 4] = res[3:0];
        end
    end

    // Select the step that matches the number system.
    always_comb begin : pick_step
        nxt = bcd ? bcd_next : bin_next;
    end

    // Guard: a valid decimal input always yields a valid decimal output.
    always_comb begin : bcd_guard
        // R8
        if (bcd && digits_ok(cur)) begin
            bcd_digit_chk: assert (digits_ok(nxt));
        end
    end

endmodule

// File: rtl/pit_host_if.sv
// Host bus decode. Turns the address and strobes into per-channel write,
// read, program and snapshot pulses, and splits the control byte into its
// fields. Assumes NUM_CH <= 3 so the control port sits at address NUM_CH.
module pit_host_if
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_CH-1:0] ctrl_we,
    output logic [NUM_CH-1:0] latch_req,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re,
    output access_e           cw_acc,
    output mode_e             cw_mode,
    output logic              cw_bcd
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);
    localparam int SEL_LSB  = 6;
    localparam int ACC_LSB  = 4;
    localparam int MODE_LSB = 1;

    logic      ctrl_hit;
    logic [1:0] cw_sel;
    mode_sel_t ms;

    // Split the control byte into its fields.
    always_comb begin : field_split
        ctrl_hit = wr && (addr == CTRL_ADDR);
        cw_sel   = wdata[SEL_LSB +: 2];
        cw_acc   = access_e'(wdata[ACC_LSB +: 2]);
        ms       = map_mode(wdata[MODE_LSB +: 3]);
        cw_mode  = ms.mode;
        cw_bcd   = wdata[0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        localparam logic [1:0]        SEL_IDX  = 2'(g);
        localparam logic [ADDR_W-1:0] PORT_IDX = ADDR_W'(g);
        // Per-channel strobes from address and control-byte fields.
        always_comb begin : chan_strobe
            ctrl_we[g]   = ctrl_hit && (cw_sel == SEL_IDX) && (cw_acc != ACC_LATCH) && ms.ok;
            latch_req[g] = ctrl_hit && (cw_sel == SEL_IDX) && (cw_acc == ACC_LATCH);
            data_we[g]   = wr && (addr == PORT_IDX);
            data_re[g]   = rd && (addr == PORT_IDX);
        end
    end

endmodule

// File: rtl/pit_channel.sv
// One timer channel: configuration, byte-serial count load, down counter
// with mode-specific output, and the snapshot/read path. Assumes the host
// strobes are single-cycle and that at most one of them is active per cycle.
module pit_channel
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              gate,
    input  logic              ctrl_we,
    input  logic              latch_req,
    input  access_e           cw_acc,
    input  mode_e             cw_mode,
    input  logic              cw_bcd,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic              tmr_out
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    access_e           acc_q;
    mode_e             mode_q;
    logic              bcd_q;
    logic              wptr_q;
    logic [DATA_W-1:0] stage_q;
    logic [CNT_W-1:0]  reload_q;

    logic [CNT_W-1:0]  count_q;
    logic              run_q;
    logic              load_pend_q;
    logic              extra_q;
    logic              out_q;

    logic [CNT_W-1:0]  hold_q;
    logic              latched_q;
    logic              rptr_q;

    logic              write_done;
    logic [CNT_W-1:0]  reload_even;
    logic [CNT_W-1:0]  dec_val;
    logic [CNT_W-1:0]  src;

    // Completion of a count write and the even part of the reload.
    always_comb begin : load_flags
        write_done  = data_we && ((acc_q != ACC_WORD) || wptr_q);
        reload_even = {reload_q[CNT_W-1:1], 1'b0};
    end

    pit_decrement #(.CNT_W(CNT_W)) u_dec (
        .cur    (count_q),
        .bcd    (bcd_q),
        .by_two (mode_q == MODE_SQUARE),
        .nxt    (dec_val)
    );

    // Configuration and byte-serial assembly of the reload value.
    always_ff @(posedge clk) begin : config_path
        if (!rst_n) begin
            acc_q    <= ACC_WORD;
            mode_q   <= MODE_TC;
            bcd_q    <= 1'b0;
            wptr_q   <= 1'b0;
            stage_q  <= '0;
            reload_q <= '0;
        end else if (ctrl_we) begin
            acc_q  <= cw_acc;
            mode_q <= cw_mode;
            bcd_q  <= cw_bcd;
            wptr_q <= 1'b0;
        end else if (data_we) begin
            case (acc_q)
                ACC_LO: reload_q <= {{DATA_W{1'b0}}, wdata};
                ACC_HI: reload_q <= {wdata, {DATA_W{1'b0}}};
                ACC_WORD: begin
                    if (!wptr_q) begin
                        stage_q <= wdata;
                        wptr_q  <= 1'b1;
                    end else begin
                        reload_q <= {wdata, stage_q};
                        wptr_q   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Counter, reload and output waveform for the three modes.
    always_ff @(posedge clk) begin : count_path
        if (!rst_n) begin
            count_q     <= '0;
            run_q       <= 1'b0;
            load_pend_q <= 1'b0;
            extra_q     <= 1'b0;
            out_q       <= 1'b1;
        end else if (ctrl_we) begin
            run_q       <= 1'b0;
            load_pend_q <= 1'b0;
            extra_q     <= 1'b0;
            out_q       <= (cw_mode != MODE_TC);
        end else begin
            if (cnt_en) begin
                if (load_pend_q) begin
                    run_q       <= 1'b1;
                    load_pend_q <= 1'b0;
                    if (mode_q == MODE_SQUARE) begin
                        count_q <= reload_even;
                        extra_q <= reload_q[0];
                        out_q   <= 1'b1;
                    end else begin
                        count_q <= reload_q;
                        extra_q <= 1'b0;
                        out_q   <= (mode_q != MODE_TC);
                    end
                end else if (run_q && gate) begin
                    case (mode_q)
                        MODE_RATE: begin
                            if (count_q == ONE) begin
                                count_q <= reload_q;
                                out_q   <= 1'b1;
                            end else begin
                                count_q <= dec_val;
                                if (count_q == TWO) out_q <= 1'b0;
                            end
                        end
                        MODE_SQUARE: begin
                            if (count_q == TWO) begin
                                if (extra_q) begin
                                    extra_q <= 1'b0;
                                end else begin
                                    out_q   <= ~out_q;
                                    count_q <= reload_even;
                                    extra_q <= reload_q[0] & ~out_q;
                                end
                            end else begin
                                count_q <= dec_val;
                            end
                        end
                        default: begin
                            count_q <= dec_val;
                            if (count_q == ONE) out_q <= 1'b1;
                        end
                    endcase
                end
            end
            if (write_done) begin
                load_pend_q <= 1'b1;
                if (mode_q == MODE_TC) out_q <= 1'b0;
            end
        end
    end

    // Snapshot capture, release and read-pointer sequencing.
    always_ff @(posedge clk) begin : read_path
        if (!rst_n) begin
            hold_q    <= '0;
            latched_q <= 1'b0;
            rptr_q    <= 1'b0;
        end else if (ctrl_we) begin
            latched_q <= 1'b0;
            rptr_q    <= 1'b0;
        end else if (latch_req && !latched_q) begin
            hold_q    <= count_q;
            latched_q <= 1'b1;
        end else if (data_re) begin
            if (acc_q == ACC_WORD) begin
                rptr_q <= ~rptr_q;
                if (rptr_q) latched_q <= 1'b0;
            end else begin
                latched_q <= 1'b0;
            end
        end
    end

    // Byte presented on the read port.
    always_comb begin : read_mux
        src = latched_q ? hold_q : count_q;
        case (acc_q)
            ACC_HI:   rd_byte = src[CNT_W-1 -: DATA_W];
            ACC_WORD: rd_byte = rptr_q ? src[CNT_W-1 -: DATA_W] : src[DATA_W-1:0];
            default:  rd_byte = src[DATA_W-1:0];
        endcase
    end

    assign tmr_out = out_q;

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !gate && run_q && !load_pend_q && !ctrl_we) |=> $stable(count_q));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && $past(latched_q)) |-> $stable(hold_q));

    // R6
    rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && mode_q == MODE_RATE && !out_q) |-> (count_q == ONE));

    // R5
    tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TC && $rose(out_q)) |-> (count_q == '0));

    // R7
    sq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && mode_q == MODE_SQUARE && $past(mode_q) == MODE_SQUARE
         && !$past(load_pend_q) && out_q != $past(out_q)) |-> ($past(count_q) == TWO));

endmodule

// File: rtl/pit_timer.sv
// Top level of the interval timer: host decode, one channel per generate
// iteration and the read-data multiplexer. Assumes NUM_CH <= 3 so the
// channel ports and the control port fit in the 2-bit address.
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] tmr_out
);
    localparam int ADDR_W = 2;

    logic [NUM_CH-1:0] ctrl_we;
    logic [NUM_CH-1:0] latch_req;
    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] data_re;
    access_e           cw_acc;
    mode_e             cw_mode;
    logic              cw_bcd;
    logic [DATA_W-1:0] ch_byte [NUM_CH];

    pit_host_if #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_host (
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .ctrl_we   (ctrl_we),
        .latch_req (latch_req),
        .data_we   (data_we),
        .data_re   (data_re),
        .cw_acc    (cw_acc),
        .cw_mode   (cw_mode),
        .cw_bcd    (cw_bcd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pit_channel #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_en    (tick_en[g]),
            .gate      (gate[g]),
            .ctrl_we   (ctrl_we[g]),
            .latch_req (latch_req[g]),
            .cw_acc    (cw_acc),
            .cw_mode   (cw_mode),
            .cw_bcd    (cw_bcd),
            .data_we   (data_we[g]),
            .data_re   (data_re[g]),
            .wdata     (bus_wdata),
            .rd_byte   (ch_byte[g]),
            .tmr_out   (tmr_out[g])
        );
    end

    // Return the addressed channel byte; the control port reads as zero.
    always_comb begin : rdata_mux
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = ch_byte[i];
        end
    end

endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] tick_en = '0;
    logic [2:0] gate = 3'b111;
    logic [2:0] tmr_out;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .gate(gate), .tmr_out(tmr_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(input logic [1:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a, hi);
        v = {hi, lo};
    endtask

    task automatic wr16(input logic [1:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a, v[15:8]);
    endtask

    task automatic tick(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = m;
            @(negedge clk);
            tick_en = '0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [15:0] w;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 outputs high", int'(tmr_out), 7);
        rd16(2'd0, w);
        chk("R1 count zero", int'(w), 0);
        rd(2'd3, b);
        chk("R12 control port reads zero", int'(b), 0);

        // R5 / R4 / R12: mode 0 sweep on channel 0
        for (int n = 1; n <= 20; n++) begin
            wr(2'd3, 8'h30);
            chk("R5 low on programming", int'(tmr_out[0]), 0);
            wr16(2'd0, 16'(n));
            tick(3'b001, 1);
            rd16(2'd0, w);
            chk("R4 load without decrement", int'(w), n);
            for (int k = 1; k <= n; k++) begin
                tick(3'b001, 1);
                chk("R5 terminal count edge", int'(tmr_out[0]), int'(k == n));
            end
            tick(3'b001, 2);
            chk("R5 stays high", int'(tmr_out[0]), 1);
            rd16(2'd0, w);
            chk("R9 binary wrap after terminal count", int'(w), 16'hFFFE);
        end

        // R6: rate generator sweep on channel 1
        for (int n = 2; n <= 10; n++) begin
            wr(2'd3, 8'h74);
            chk("R6 high on programming", int'(tmr_out[1]), 1);
            wr16(2'd1, 16'(n));
            tick(3'b010, 1);
            for (int k = 1; k <= 2 * n; k++) begin
                tick(3'b010, 1);
                chk("R6 pulse position", int'(tmr_out[1]), int'((k % n) != (n - 1)));
            end
        end

        // R7: square wave sweep on channel 2
        for (int n = 2; n <= 11; n++) begin
            wr(2'd3, 8'hB6);
            wr16(2'd2, 16'(n));
            tick(3'b100, 1);
            for (int k = 1; k <= 2 * n; k++) begin
                tick(3'b100, 1);
                chk("R7 square phase", int'(tmr_out[2]), int'((k % n) < ((n + 1) / 2)));
            end
        end

        // R2: mode field alias 6 behaves as rate generator
        wr(2'd3, 8'h7C);
        wr16(2'd1, 16'd3);
        tick(3'b010, 1);
        for (int k = 1; k <= 6; k++) begin
            tick(3'b010, 1);
            chk("R2 mode alias", int'(tmr_out[1]), int'((k % 3) != 2));
        end

        // R2: reserved mode and channel select 3 are ignored
        wr(2'd3, 8'h74);
        wr16(2'd1, 16'd4);
        tick(3'b010, 2);
        wr(2'd3, 8'h72);
        wr(2'd3, 8'hF4);
        tick(3'b010, 1);
        chk("R2 reserved ignored t2", int'(tmr_out[1]), 1);
        tick(3'b010, 1);
        chk("R2 reserved ignored t3", int'(tmr_out[1]), 0);
        tick(3'b010, 1);
        chk("R2 reserved ignored t4", int'(tmr_out[1]), 1);

        // R8: BCD counting
        wr(2'd3, 8'h31);
        wr16(2'd0, 16'h0010);
        tick(3'b001, 1);
        for (int k = 1; k <= 10; k++) begin
            tick(3'b001, 1);
            chk("R8 BCD terminal count", int'(tmr_out[0]), int'(k == 10));
        end
        wr(2'd3, 8'h31);
        wr16(2'd0, 16'h0100);
        tick(3'b001, 2);
        rd16(2'd0, w);
        chk("R8 BCD borrow", int'(w), 16'h0099);
        tick(3'b001, 9);
        rd16(2'd0, w);
        chk("R8 BCD digits", int'(w), 16'h0090);
        wr(2'd3, 8'h75);
        wr16(2'd1, 16'h0012);
        tick(3'b010, 1);
        for (int k = 1; k <= 12; k++) begin
            tick(3'b010, 1);
            chk("R8 BCD rate period", int'(tmr_out[1]), int'(k != 11));
        end

        // R9: zero reload in both number systems
        wr(2'd3, 8'h31);
        wr16(2'd0, 16'h0000);
        tick(3'b001, 2);
        rd16(2'd0, w);
        chk("R9 BCD zero", int'(w), 16'h9999);
        tick(3'b001, 1);
        rd16(2'd0, w);
        chk("R9 BCD zero next", int'(w), 16'h9998);
        wr(2'd3, 8'h30);
        wr16(2'd0, 16'h0000);
        tick(3'b001, 2);
        rd16(2'd0, w);
        chk("R9 binary zero", int'(w), 16'hFFFF);

        // R11: snapshot with low-then-high access
        wr(2'd3, 8'h34);
        wr16(2'd0, 16'd100);
        tick(3'b001, 11);
        wr(2'd3, 8'h00);
        tick(3'b001, 5);
        rd16(2'd0, w);
        chk("R11 held value", int'(w), 90);
        rd16(2'd0, w);
        chk("R11 released to live", int'(w), 85);
        wr(2'd3, 8'h00);
        tick(3'b001, 3);
        wr(2'd3, 8'h00);
        rd16(2'd0, w);
        chk("R11 second snapshot ignored", int'(w), 85);
        rd16(2'd0, w);
        chk("R12 live read", int'(w), 82);

        // R11 / R3: snapshot with low-only access
        wr(2'd3, 8'h10);
        wr(2'd0, 8'd50);
        tick(3'b001, 6);
        wr(2'd3, 8'h00);
        tick(3'b001, 2);
        rd(2'd0, b);
        chk("R11 single-byte hold", int'(b), 45);
        rd(2'd0, b);
        chk("R11 single-byte release", int'(b), 43);

        // R3: low-only count with terminal count timing
        wr(2'd3, 8'h10);
        wr(2'd0, 8'd7);
        tick(3'b001, 1);
        for (int k = 1; k <= 7; k++) begin
            tick(3'b001, 1);
            chk("R3 low-only count", int'(tmr_out[0]), int'(k == 7));
        end

        // R3: high-only count and read
        wr(2'd3, 8'h20);
        wr(2'd0, 8'h01);
        tick(3'b001, 1);
        rd(2'd0, b);
        chk("R3 high-only read", int'(b), 1);
        tick(3'b001, 1);
        rd(2'd0, b);
        chk("R3 high byte after decrement", int'(b), 0);

        // R3: programming byte resets pointers
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h55);
        rd(2'd0, b);
        wr(2'd3, 8'h30);
        wr16(2'd0, 16'h1234);
        tick(3'b001, 1);
        rd16(2'd0, w);
        chk("R3 pointer reset", int'(w), 16'h1234);

        // R10: gate low suspends counting
        gate[0] = 1'b0;
        wr(2'd3, 8'h30);
        wr16(2'd0, 16'd5);
        tick(3'b001, 11);
        chk("R10 output held", int'(tmr_out[0]), 0);
        rd16(2'd0, w);
        chk("R10 count held", int'(w), 5);
        gate[0] = 1'b1;
        tick(3'b001, 4);
        chk("R10 resumes low", int'(tmr_out[0]), 0);
        tick(3'b001, 1);
        chk("R10 resumes terminal", int'(tmr_out[0]), 1);

        // R13: channel independence
        wr(2'd3, 8'h30);
        wr16(2'd0, 16'd9);
        tick(3'b001, 1);
        wr(2'd3, 8'h74);
        wr16(2'd1, 16'd7);
        tick(3'b010, 6);
        rd16(2'd0, w);
        chk("R13 channel 0 untouched", int'(w), 9);
        rd16(2'd1, w);
        chk("R13 channel 1 counted", int'(w), 2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule